// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with a small set of 16-bit registers. They are reached through a plain write strobe and a combinational read port. A half-second tick input drives a down-counter. The counter is loaded from an 8-bit timeout field, and each field step adds one half-second tick. Software keeps the system alive by writing an ordered pair of key words to the service register. When the counter runs out, the block pulses a system reset request and records that a timeout caused it.

Software can also ask for a reset directly, by writing zero to a request bit in the control register. That cause is recorded as distinct from a timeout. A pre-timeout interrupt can be armed at a chosen number of ticks before expiry. Its status flag is cleared by writing one. An external watchdog line can be driven by software, or latched by a timeout. Counting can be suspended in low-power, debug or wait conditions, and each of these has its own control bit.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the registers read as follows: control (addr 0x0) reads 0x0030, reset status (0x4) reads 0x0000, interrupt control (0x6) reads 0x0000 and misc (0x8) reads 0x0001. The outputs rst_req, irq and ext_wd are 0. The service register (0x2) and unused addresses read 0.
- R2: The control register layout is as follows.
  - Bits 15:8 hold the timeout field WT. It stays writable at any time.
  - Bit 7 is wait suspend, bit 3 is timeout-to-external-line, bit 1 is debug suspend and bit 0 is low-power suspend.
  - Bit 5 is the external line control. It resets to 1.
  - Bit 4 is the software reset request. It always reads 1.
  - Bit 2 is the enable. Once it is written to 1 it stays 1 until rst_n.
  - Bit 6 reads 0.
- R3: When enable rises, the counter loads WT+1. On each counted tick it decrements. On the tick that finds it at 1, rst_req is high for exactly the following clock cycle, the counter reloads WT+1, and reset status reads 0x0002 (bit 1 set means a timeout). So WT=0 expires on every tick and WT=0xFF expires on the 256th tick.
- R4: Writing 0x5555 and then 0xAAAA to the service register reloads the counter with WT+1.
- R5: Any service write other than the expected next key clears the key detector. This means 0xAAAA alone, or 0x5555 followed by another value and then 0xAAAA, does not reload the counter.
- R6: A control write with bit 4 equal to 0 makes rst_req high for the next cycle and sets reset status to 0x0001 (bit 0 set means software). The counter is not changed.
- R7: A tick is not counted while a suspend is in effect: control bit 0 with lp_mode, bit 1 with dbg_mode, or bit 7 with wait_mode. A mode input whose control bit is 0 has no effect.
- R8: Interrupt control has the count N in bits 7:0, the status flag in bit 14 and the enable in bit 15.
  - The status flag sets on the counted tick that leaves N ticks remaining.
  - Writing 1 to bit 14 clears the flag. Writing 0 to bit 14 leaves it unchanged.
  - irq equals status AND enable.
- R9: ext_wd is high while control bit 5 is 0. If control bit 3 is 1 when a timeout occurs, ext_wd latches high until rst_n.
- R10: Reset status ignores writes. Misc register bit 0 is a read/write flag, and its other bits read 0.
- R11: While the enable bit is 0, ticks neither count nor cause a reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse every half second |
| lp_mode | input | 1 | Low-power state indication |
| dbg_mode | input | 1 | Debug halt indication |
| wait_mode | input | 1 | Wait state indication |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address (halfword aligned) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| rst_req | output | 1 | One-cycle system reset request |
| ext_wd | output | 1 | External watchdog line, active high |
| irq | output | 1 | Pre-timeout interrupt |

## Verification
The assertions check several properties on every cycle:
- the enable and the latched external line never fall once set;
- every reset request coincides with exactly one recorded cause;
- the counter never holds zero;
- the counter stays still when neither a tick nor a write arrives, and while the block is disabled;
- the interrupt flag only rises on a tick.

Only the bench scenarios can show the following:
- the exact tick on which expiry lands for WT values of 0, 2 and 0xFF;
- that the key pair must arrive in order;
- that each suspend input is gated by its own control bit;
- write-one-to-clear behaviour;
- the read values of each register.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter logic [15:0] KEY_A = 16'h5555,
  parameter logic [15:0] KEY_B = 16'hAAAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        lp_mode,
  input  logic        dbg_mode,
  input  logic        wait_mode,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        rst_req,
  output logic        ext_wd,
  output logic        irq
);
  localparam int TW = 8;
  localparam int CW = TW + 1;
  localparam logic [3:0] A_CTL = 4'h0;
  localparam logic [3:0] A_SVC = 4'h2;
  localparam logic [3:0] A_RSR = 4'h4;
  localparam logic [3:0] A_ICR = 4'h6;
  localparam logic [3:0] A_MCR = 4'h8;

  logic [TW-1:0] wt_q, wict_q;
  logic [CW-1:0] cnt_q;
  logic en_q, lpz_q, dbg_q, wdw_q, tout_ext_q, ext_n_q;
  logic armed_q, ext_lat_q, to_q, sw_q, wis_q, wie_q, pde_q;

  wire wr_ctl = wr_en && addr == A_CTL;
  wire wr_svc = wr_en && addr == A_SVC;
  wire wr_icr = wr_en && addr == A_ICR;
  wire wr_mcr = wr_en && addr == A_MCR;

  wire susp     = (lpz_q & lp_mode) | (dbg_q & dbg_mode) | (wdw_q & wait_mode);
  wire step     = en_q && tick && !susp;
  wire expire   = step && cnt_q == CW'(1);
  wire svc_done = wr_svc && wdata == KEY_B && armed_q;
  wire en_rise  = wr_ctl && wdata[2] && !en_q;
  wire sw_req   = wr_ctl && !wdata[4];
  wire [CW-1:0] reload = CW'(wt_q) + CW'(1);
  wire [CW-1:0] cnt_dec = cnt_q - CW'(1);
  wire int_hit  = step && !expire && cnt_dec == CW'(wict_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_q       <= '0;
      en_q       <= 1'b0;
      lpz_q      <= 1'b0;
      dbg_q      <= 1'b0;
      wdw_q      <= 1'b0;
      tout_ext_q <= 1'b0;
      ext_n_q    <= 1'b1;
    end else if (wr_ctl) begin
      wt_q       <= wdata[15:8];
      en_q       <= en_q | wdata[2];
      lpz_q      <= wdata[0];
      dbg_q      <= wdata[1];
      wdw_q      <= wdata[7];
      tout_ext_q <= wdata[3];
      ext_n_q    <= wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(1);
    end else if (en_rise) begin
      cnt_q <= CW'(wdata[15:8]) + CW'(1);
    end else if (svc_done) begin
      cnt_q <= reload;
    end else if (step) begin
      cnt_q <= expire ? reload : cnt_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (wr_svc) armed_q <= wdata == KEY_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req   <= 1'b0;
      to_q      <= 1'b0;
      sw_q      <= 1'b0;
      ext_lat_q <= 1'b0;
    end else begin
      rst_req   <= expire | sw_req;
      ext_lat_q <= ext_lat_q | (expire & tout_ext_q);
      if (expire) begin
        to_q <= 1'b1;
        sw_q <= 1'b0;
      end else if (sw_req) begin
        to_q <= 1'b0;
        sw_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wict_q <= '0;
      wie_q  <= 1'b0;
      wis_q  <= 1'b0;
      pde_q  <= 1'b1;
    end else begin
      if (wr_icr) begin
        wict_q <= wdata[7:0];
        wie_q  <= wdata[15];
      end
      if (int_hit)                  wis_q <= 1'b1;
      else if (wr_icr && wdata[14]) wis_q <= 1'b0;
      if (wr_mcr) pde_q <= wdata[0];
    end
  end

  assign ext_wd = ext_lat_q | ~ext_n_q;
  assign irq    = wis_q & wie_q;

  always_comb begin
    case (addr)
      A_CTL:   rdata = {wt_q, wdw_q, 1'b0, ext_n_q, 1'b1, tout_ext_q, en_q, dbg_q, lpz_q};
      A_RSR:   rdata = {14'b0, to_q, sw_q};
      A_ICR:   rdata = {wie_q, wis_q, 6'b0, wict_q};
      A_MCR:   rdata = {15'b0, pde_q};
      default: rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic          rst_req,
  input logic          en_q,
  input logic [CW-1:0] cnt_q,
  input logic          wis_q,
  input logic          ext_lat_q,
  input logic          to_q,
  input logic          sw_q
);
  p_sticky_en_r2: assert property (@(posedge clk) disable iff (!rst_n) en_q |=> en_q);
  p_cause_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $countones({to_q, sw_q}) == 1);
  p_cnt_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n) cnt_q != '0);
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt_q));
  p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> $stable(cnt_q));
  p_irq_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wis_q) |-> $past(tick));
  p_ext_latch_r9: assert property (@(posedge clk) disable iff (!rst_n) ext_lat_q |=> ext_lat_q);
endmodule

bind wdog_keyed wdog_keyed_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rst_req(rst_req),
  .en_q(en_q), .cnt_q(cnt_q), .wis_q(wis_q), .ext_lat_q(ext_lat_q),
  .to_q(to_q), .sw_q(sw_q)
);

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, lp_mode = 1'b0, dbg_mode = 1'b0, wait_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic rst_req, ext_wd, irq;
  int checks = 0, failures = 0, hits;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_keyed dut (.clk(clk), .rst_n(rst_n), .tick(tick), .lp_mode(lp_mode),
    .dbg_mode(dbg_mode), .wait_mode(wait_mode), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .ext_wd(ext_wd), .irq(irq));

  localparam logic [35:0] VEC [0:7] = '{
    {4'h6, 16'h8005, 16'h8005},
    {4'h6, 16'h00FF, 16'h00FF},
    {4'h8, 16'h0000, 16'h0000},
    {4'h8, 16'hFFFF, 16'h0001},
    {4'h4, 16'hFFFF, 16'h0000},
    {4'h0, 16'h0330, 16'h0330},
    {4'h0, 16'h05F3, 16'h05B3},
    {4'hA, 16'h1234, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (rst_req) h++;
    end
  endtask

  task automatic chk_rd(input string tag, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk_rd("R1 ctl reset", 4'h0, 16'h0030);
    chk_rd("R1 rsr reset", 4'h4, 16'h0000);
    chk_rd("R1 icr reset", 4'h6, 16'h0000);
    chk_rd("R1 mcr reset", 4'h8, 16'h0001);
    chk_rd("R1 svc reads 0", 4'h2, 16'h0000);
    chk("R1 outputs", {13'b0, rst_req, irq, ext_wd}, 16'h0000);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      chk_rd($sformatf("R2 R10 vector %0d", i), VEC[i][35:32], VEC[i][15:0]);
    end
    wr(4'h6, 16'h0000);
    wr(4'h0, 16'h0030);

    ticks(3, hits);
    chk("R11 disabled no reset", 16'(hits), 16'd0);

    wr(4'h0, 16'h0234);
    ticks(2, hits); chk("R3 no early expiry", 16'(hits), 16'd0);
    ticks(1, hits); chk("R3 expiry on WT+1 tick", 16'(hits), 16'd1);
    @(negedge clk); chk("R3 one-cycle pulse", {15'b0, rst_req}, 16'h0000);
    chk_rd("R3 timeout cause", 4'h4, 16'h0002);
    wr(4'h0, 16'h0230);
    chk_rd("R2 enable sticky", 4'h0, 16'h0234);

    ticks(2, hits);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    ticks(2, hits); chk("R4 service reloads", 16'(hits), 16'd0);
    ticks(1, hits); chk("R4 expiry after reload", 16'(hits), 16'd1);

    ticks(2, hits);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    ticks(1, hits); chk("R5 broken sequence ignored", 16'(hits), 16'd1);
    ticks(2, hits);
    wr(4'h2, 16'hAAAA);
    ticks(1, hits); chk("R5 second key alone ignored", 16'(hits), 16'd1);

    wr(4'h0, 16'h0235); lp_mode = 1'b1;
    ticks(5, hits); chk("R7 low-power suspend", 16'(hits), 16'd0);
    lp_mode = 1'b0; dbg_mode = 1'b1;
    ticks(2, hits); chk("R7 ungated debug no effect a", 16'(hits), 16'd0);
    ticks(1, hits); chk("R7 ungated debug no effect b", 16'(hits), 16'd1);
    dbg_mode = 1'b0;
    wr(4'h0, 16'h02B4); wait_mode = 1'b1;
    ticks(4, hits); chk("R7 wait suspend", 16'(hits), 16'd0);
    wait_mode = 1'b0;
    wr(4'h0, 16'h0234);

    wr(4'h6, 16'h8001);
    ticks(1, hits); chk("R8 irq not yet", {15'b0, irq}, 16'h0000);
    ticks(1, hits); chk("R8 irq at N remaining", {15'b0, irq}, 16'h0001);
    chk_rd("R8 status set", 4'h6, 16'hC001);
    wr(4'h6, 16'h8001);
    chk_rd("R8 write zero keeps status", 4'h6, 16'hC001);
    wr(4'h6, 16'hC001);
    chk_rd("R8 w1c clears", 4'h6, 16'h8001);
    chk("R8 irq cleared", {15'b0, irq}, 16'h0000);
    ticks(1, hits); chk("R8 expiry", 16'(hits), 16'd1);
    wr(4'h6, 16'h0001);
    ticks(2, hits); chk("R8 irq masked", {15'b0, irq}, 16'h0000);
    chk_rd("R8 status without enable", 4'h6, 16'h4001);
    ticks(1, hits);
    wr(4'h6, 16'h4000);
    chk_rd("R8 cleared", 4'h6, 16'h0000);

    wr(4'h0, 16'h0224);
    chk("R6 sw reset pulse", {15'b0, rst_req}, 16'h0001);
    @(negedge clk); chk("R6 pulse ends", {15'b0, rst_req}, 16'h0000);
    chk_rd("R6 sw cause", 4'h4, 16'h0001);
    chk_rd("R6 request bit reads 1", 4'h0, 16'h0234);
    ticks(2, hits); chk("R6 counter untouched a", 16'(hits), 16'd0);
    ticks(1, hits); chk("R6 counter untouched b", 16'(hits), 16'd1);

    wr(4'h0, 16'h0214); chk("R9 sw ext assert", {15'b0, ext_wd}, 16'h0001);
    wr(4'h0, 16'h0234); chk("R9 sw ext release", {15'b0, ext_wd}, 16'h0000);
    wr(4'h0, 16'h023C);
    ticks(2, hits); chk("R9 not before timeout", {15'b0, ext_wd}, 16'h0000);
    ticks(1, hits); chk("R9 latched on timeout", {15'b0, ext_wd}, 16'h0001);
    wr(4'h0, 16'h0234); chk("R9 stays latched", {15'b0, ext_wd}, 16'h0001);

    do_reset();
    chk("R1 ext cleared by reset", {15'b0, ext_wd}, 16'h0000);
    chk_rd("R1 ctl after reset", 4'h0, 16'h0030);
    wr(4'h0, 16'h0534);
    wr(4'h0, 16'h0034);
    chk_rd("R2 WT writable while enabled", 4'h0, 16'h0034);
    ticks(5, hits); chk("R3 loaded value kept", 16'(hits), 16'd0);
    ticks(1, hits); chk("R3 expiry", 16'(hits), 16'd1);
    ticks(1, hits); chk("R3 WT zero every tick", 16'(hits), 16'd1);
    wr(4'h0, 16'hFF34);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    ticks(255, hits); chk("R3 WT max no early", 16'(hits), 16'd0);
    ticks(1, hits); chk("R3 WT max 256th tick", 16'(hits), 16'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule